// File: doc/BRIEF.md
# Program-Status Read Responder

This block shapes the word driven back onto a memory read bus while an internal program cycle runs. When the controller is busy, normal array data is replaced by status. In each byte lane, the top bit reports the complement of the most recently loaded word whenever the read address matches that word's address. The next bit down flips from one completed read access to the next. All other bits carry the loaded word's true data. When the cycle is over, array read data passes through unchanged.

The read strobe is active when chip enable and output enable are both low and write enable is high. The strobe also produces the enable for the external tristate buffers. The toggling status bit advances only when a read access finishes, that is, when the read strobe deasserts. It does not advance on clock cycles, so a read held for many cycles always sees one stable value. Software can therefore poll either the complemented bit or the toggling bit to find out when programming has completed.

Top module: `prog_status_resp`

## Requirements
- R1: `driveEn` is 1 exactly when `ceN` is 0, `oeN` is 0 and `weN` is 1; in every other combination of the three strobes it is 0.
- R2: While `busy` is 0, `rdData` equals `arrayData` on every bit.
- R3: While `busy` is 1 and `rdAddr` equals `lastAddr`, bit 8k+7 of `rdData` (bits 7 and 15 for 16-bit data) is the complement of the same bit of `lastData`.
- R4: While `busy` is 1 and `rdAddr` differs from `lastAddr`, bit 8k+7 of `rdData` equals the same bit of `lastData`.
- R5: While `busy` is 1, bit 8k+6 of `rdData` (bits 6 and 14) shows the toggle state, which is 0 on the first read after `busy` rises. This holds from the first cycle in which `busy` is high.
- R6: The toggle state inverts once at the end of each read access made while `busy` is 1. It holds steady for the whole of a read, however many cycles the read lasts. An access with `weN` low is not a read and does not advance the toggle.
- R7: While `busy` is 1, every bit of `rdData` other than 8k+6 and 8k+7 equals `lastData`.
- R8: After reset, and after any clock edge at which `busy` is 0, the toggle state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Internal program cycle in progress |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| lastData | input | DATA_W | Word most recently loaded for programming |
| lastAddr | input | ADDR_W | Address of that word |
| rdAddr | input | ADDR_W | Current read address |
| arrayData | input | DATA_W | Data read from the storage array |
| rdData | output | DATA_W | Word to drive on the bus |
| driveEn | output | 1 | Enable for the bus tristate buffers |

## Verification
`rdData` and `driveEn` are combinational from the strobes, the addresses and the toggle state, so the bench checks them in the same cycle it drives the inputs, 1 ns after the falling clock edge. The toggle state is a register. A read released at one falling edge advances it at the following rising edge, so the bench updates its own toggle model only after that falling edge has passed. Clearing when `busy` drops also takes effect at the next rising edge, and the bench always lets a full clock pass before it checks that effect.

// File: rtl/prog_status_pkg.sv
package prog_status_pkg;
  // Strobes handed from control to datapath
  typedef struct packed {
    logic driveEn;     // read strobe active
    logic showStatus;  // program cycle in progress
    logic toggleVal;   // current toggle status bit
  } statusStrobe_t;
endpackage

// File: rtl/prog_status_ctrl.sv
module prog_status_ctrl
  import prog_status_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          busy,
  input  logic          ceN,
  input  logic          oeN,
  input  logic          weN,
  output statusStrobe_t strb
);
  logic readNow;
  logic readPrev;
  logic readEnd;
  logic toggleQ;

  assign readNow = ~ceN & ~oeN & weN;
  assign readEnd = readPrev & ~readNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPrev <= 1'b0;
      toggleQ  <= 1'b0;
    end else begin
      readPrev <= readNow;
      if (!busy)
        toggleQ <= 1'b0;
      else if (readEnd)
        toggleQ <= ~toggleQ;
    end
  end

  always_comb begin
    strb.driveEn    = readNow;
    strb.showStatus = busy;
    strb.toggleVal  = toggleQ;
  end
endmodule

// File: rtl/prog_status_dp.sv
module prog_status_dp
  import prog_status_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  statusStrobe_t       strb,
  input  logic [DATA_W-1:0]   lastData,
  input  logic [ADDR_W-1:0]   lastAddr,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   arrayData,
  output logic [DATA_W-1:0]   rdData
);
  localparam int LANES = DATA_W / 8;

  logic pollHit;
  assign pollHit = (rdAddr == lastAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] statusLane;
    always_comb begin
      statusLane      = lastData[8*g +: 8];
      statusLane[7]   = pollHit ? ~lastData[8*g+7] : lastData[8*g+7];
      statusLane[6]   = strb.toggleVal;
    end
    assign rdData[8*g +: 8] = strb.showStatus ? statusLane : arrayData[8*g +: 8];
  end
endmodule

// File: rtl/prog_status_resp.sv
module prog_status_resp
  import prog_status_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [DATA_W-1:0] lastData,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              driveEn
);
  statusStrobe_t strb;

  prog_status_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .busy(busy),
    .ceN(ceN), .oeN(oeN), .weN(weN), .strb(strb)
  );

  prog_status_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpI (
    .strb(strb), .lastData(lastData), .lastAddr(lastAddr),
    .rdAddr(rdAddr), .arrayData(arrayData), .rdData(rdData)
  );

  assign driveEn = strb.driveEn;
endmodule

// File: rtl/prog_status_resp_chk.sv
module prog_status_resp_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic [DATA_W-1:0] lastData,
  input logic [ADDR_W-1:0] lastAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] rdData,
  input logic              driveEn
);
  assert_no_drive_deselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN || !weN) |-> !driveEn);

  assert_pass_through_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rdData == arrayData);

  assert_poll_complement_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdAddr == lastAddr) |-> rdData[7] == !lastData[7]);

  assert_poll_true_other_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdAddr != lastAddr) |-> rdData[7] == lastData[7]);

  assert_toggle_steady_in_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && driveEn && $past(driveEn)) |-> rdData[6] == $past(rdData[6]));

  assert_low_bits_loaded_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> rdData[5:0] == lastData[5:0]);
endmodule

bind prog_status_resp prog_status_resp_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chkI (.*);

// File: tb/prog_status_resp_test.sv
module prog_status_resp_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busy = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [15:0] lastData = '0, lastAddr = '0, rdAddr = '0, arrayData = '0;
  logic [15:0] rdData;
  logic driveEn;

  int nChecks = 0;
  int nFails = 0;
  logic expTog = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_status_resp uut (
    .clk(clk), .rstN(rstN), .busy(busy), .ceN(ceN), .oeN(oeN), .weN(weN),
    .lastData(lastData), .lastAddr(lastAddr), .rdAddr(rdAddr),
    .arrayData(arrayData), .rdData(rdData), .driveEn(driveEn)
  );

  function automatic logic [15:0] expWord(logic b, logic hit, logic [15:0] ld,
                                          logic [15:0] arr, logic tog);
    logic [15:0] w;
    if (!b) return arr;
    w = ld;
    w[6] = tog;
    w[14] = tog;
    if (hit) begin
      w[7]  = ~ld[7];
      w[15] = ~ld[15];
    end
    return w;
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkWord(input string req);
    logic [15:0] e;
    e = expWord(busy, rdAddr == lastAddr, lastData, arrayData, expTog);
    check(rdData === e && driveEn === 1'b1, req, rdData, e);
  endtask

  // One read access lasting holdCycles cycles, then release
  task automatic readAccess(input logic [15:0] addr, input int holdCycles, input string req);
    @(negedge clk);
    rdAddr = addr; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    #1 checkWord(req);
    for (int i = 1; i < holdCycles; i++) begin
      @(negedge clk);
      #1 checkWord("R6 steady during held read");
    end
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    if (busy) expTog = ~expTog;
  endtask

  task automatic setBusy(input logic b);
    @(negedge clk);
    busy = b;
    @(negedge clk);
    if (!b) expTog = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [6];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
    pats[3] = 16'h1234; pats[4] = 16'h8040; pats[5] = 16'h7FBF;

    repeat (3) @(negedge clk);
    #1 check(driveEn === 1'b0, "R1 reset no drive", {15'd0, driveEn}, 16'h0);
    rstN = 1'b1;

    // R8: toggle zero after reset, visible on first busy read
    lastData = 16'h0F0F; lastAddr = 16'h0042; arrayData = 16'h1111;
    @(negedge clk);
    busy = 1'b1;
    rdAddr = 16'h0042; ceN = 1'b0; oeN = 1'b0;
    #1 checkWord("R5 R8 status in first busy cycle");
    check(rdData[6] === 1'b0, "R8 toggle zero after reset", {15'd0, rdData[6]}, 16'h0);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    expTog = ~expTog;
    setBusy(1'b0);

    // R1: every strobe combination, busy high
    setBusy(1'b1);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      {ceN, oeN, weN} = c[2:0];
      #1 check(driveEn === (c == 1), "R1 strobe decode", {15'd0, driveEn}, {15'd0, c == 1});
      @(negedge clk);
      ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
      @(negedge clk);
      if (c == 1) expTog = ~expTog;
    end
    // R6: a write pulse while busy must not advance the toggle
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    readAccess(lastAddr, 1, "R6 write does not advance toggle");
    setBusy(1'b0);

    // Sweep patterns, address hit/miss, busy/idle
    for (int p = 0; p < 6; p++) begin
      for (int hit = 0; hit < 2; hit++) begin
        lastData  = pats[p];
        arrayData = ~pats[p] ^ 16'h3C5A;
        lastAddr  = 16'h0100 + p;
        readAccess(hit ? lastAddr : lastAddr + 16'h0080, 1, "R2 idle pass-through");
        setBusy(1'b1);
        for (int r = 0; r < 4; r++)
          readAccess(hit ? lastAddr : lastAddr ^ 16'h0001, (r == 2) ? 3 : 1,
                     hit ? "R3 R5 R6 R7 poll hit" : "R4 R5 R6 R7 poll miss");
        setBusy(1'b0);
        readAccess(lastAddr, 1, "R2 R8 true data after cycle");
      end
    end

    // R8: toggle cleared after busy drop, fresh cycle starts at 0
    setBusy(1'b1);
    readAccess(lastAddr, 1, "R8 fresh cycle toggle");
    @(negedge clk);
    rdAddr = lastAddr; ceN = 1'b0; oeN = 1'b0;
    #1 check(rdData[14] === 1'b1, "R6 second read toggled", {15'd0, rdData[14]}, 16'h1);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    setBusy(1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule